// File: doc/BRIEF.md
# Accumulator MAC Control Core

A single-issue control core whose only arithmetic is a signed multiply-accumulate into a wide two's-complement accumulator. Every clock cycle it takes one 32-bit instruction from an external instruction memory, addressed by its program counter, and executes it completely. The instructions cover:

- register and kernel multiply-accumulate
- accumulator clear and move
- load immediate
- local data-memory load and store
- weight-pointer and stream-pointer loads
- a branch on a register that is signed less than or equal to zero
- halt

The kernel multiply-accumulate reads one resident weight and one streamed operand through two combinational read ports. It then advances both local pointers. A cycle counter and a retire counter track execution for debug, and no instruction reads them. A debug read port returns any scalar register without disturbing execution.

Top module: `accmac_core`

## Requirements
- R1: A synchronous reset clears the program counter, the accumulator, both local pointers, the halted flag and both counters. The instruction address and both kernel indexes then read zero.
- R2: The instruction word holds the opcode in [31:28], field A in [27:25], field B in [24:22] and a sign-extended immediate in [21:0]. The opcodes are: 0 register MAC (A, B), 1 kernel MAC, 2 clear accumulator, 3 move accumulator to A, 4 load immediate into A, 5 load A from memory at index reg B, 6 store reg B at index reg A, 7 set weight pointer, 8 set stream pointer, 9 branch on reg A, 10 halt.
- R3: Register MAC adds the signed product of the low 32 bits of registers A and B to the accumulator, wrapping modulo 2^64.
- R4: Kernel MAC adds weight[wptr low 8 bits] times stream[sptr low 8 bits], both taken as signed 32-bit values. It then increments both 16-bit pointers with wrap. The kernel indexes are the low 8 bits of each pointer.
- R5: Clear sets the accumulator to zero. Move writes the accumulator, as a signed value, into register A.
- R6: Load immediate writes the 22-bit immediate, sign-extended to 64 bits, into register A.
- R7: Load and store index a 256-word, 64-bit data memory with the low 8 bits of the address register. Store writes all 64 bits.
- R8: Each pointer-set loads its own pointer with the low 16 bits of the immediate and leaves the other pointer unchanged.
- R9: If register A, read as signed 64-bit, is less than or equal to zero, the branch jumps to PC plus the immediate. Otherwise execution continues at PC+1.
- R10: Halt sets a sticky halted flag, keeps the PC, and counts as one cycle and one retirement. After it, no state and no counter changes until reset.
- R11: Each executed instruction increments the cycle and retire counters by one. The counters never influence any register, memory or the accumulator.
- R12: Opcodes 11 to 15 retire as no-operations that advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 64 | Program counter driving instruction fetch |
| imem_data | input | 32 | Instruction at imem_addr, same cycle |
| wt_idx | output | 8 | Weight memory read index |
| wt_data | input | 32 | Weight element at wt_idx |
| st_idx | output | 8 | Stream memory read index |
| st_data | input | 32 | Stream element at st_idx |
| dbg_sel | input | 3 | Register selected for debug read |
| dbg_data | output | 64 | Contents of register dbg_sel |
| acc_out | output | 64 | Accumulator value |
| cycle_cnt | output | 64 | Executed-cycle counter |
| retire_cnt | output | 64 | Retired-instruction counter |
| halted | output | 1 | Sticky halted flag |

## Verification
The register MAC is tried with operand pairs that are:

- both positive
- of mixed sign
- both negative
- containing zero
- at the immediate's extremes

Each pair is accumulated twice, so a lost accumulate or a sign error shows up. Two patterns aim at the datapath edges. A register with bits set above bit 31 separates low-32-bit operand selection from full-width use. Repeated products of -2^31 squared separate 64-bit wrap from saturation. The kernel MAC is run both at mid-range pointers and at the 16-bit pointer and 8-bit index wrap points. The branch program mixes taken forward, not-taken and taken backward jumps. Counter values and skipped writes then tell a wrong target apart from a wrong condition.

// File: rtl/accmac_pkg.sv
package accmac_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [3:0] {
      OP_MAC    = 4'd0,
      OP_KMAC   = 4'd1,
      OP_CLRACC = 4'd2,
      OP_MOVACC = 4'd3,
      OP_LI     = 4'd4,
      OP_LD     = 4'd5,
      OP_ST     = 4'd6,
      OP_SETW   = 4'd7,
      OP_SETS   = 4'd8,
      OP_BLEZ   = 4'd9,
      OP_HALT   = 4'd10
   } opcode_e;

   typedef enum logic [1:0] {
      WB_IMM = 2'd0,
      WB_ACC = 2'd1,
      WB_MEM = 2'd2
   } wb_src_e;

   typedef enum logic [1:0] {
      ACC_KEEP = 2'd0,
      ACC_ZERO = 2'd1,
      ACC_MAC  = 2'd2
   } acc_mode_e;

   typedef struct packed {
      logic      reg_we;
      wb_src_e   wb_src;
      acc_mode_e acc_mode;
      logic      kernel;
      logic      mem_we;
      logic      wptr_ld;
      logic      sptr_ld;
      logic      ptr_inc;
      logic      branch;
      logic      halt;
   } ctrl_t;

endpackage

// File: rtl/accmac_decode.sv
module accmac_decode
   import accmac_pkg::*;
#(
   parameter int IW   = 32,
   parameter int RB   = 3,
   parameter int XLEN = 64
) (
   input  logic [IW-1:0]   instr,
   output logic [RB-1:0]   fld_a,
   output logic [RB-1:0]   fld_b,
   output logic [XLEN-1:0] imm,
   output ctrl_t           ctrl
);

   localparam int IMMW = IW - OPC_W - 2*RB;

   generate
      if (IMMW < 2) begin : g_bad_immw
         $error("accmac_decode: instruction word too narrow for immediate");
      end
      if (XLEN < IMMW) begin : g_bad_xlen
         $error("accmac_decode: XLEN narrower than immediate");
      end
   endgenerate

   opcode_e opc;

   assign opc   = opcode_e'(instr[IW-1 -: OPC_W]);
   assign fld_a = instr[IW-OPC_W-1 -: RB];
   assign fld_b = instr[IW-OPC_W-RB-1 -: RB];

   generate
      if (XLEN > IMMW) begin : g_sext
         assign imm = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
      end else begin : g_same
         assign imm = instr[IMMW-1:0];
      end
   endgenerate

   always_comb begin
      ctrl = '0;
      unique case (opc)
         OP_MAC:    ctrl.acc_mode = ACC_MAC;
         OP_KMAC: begin
            ctrl.acc_mode = ACC_MAC;
            ctrl.kernel   = 1'b1;
            ctrl.ptr_inc  = 1'b1;
         end
         OP_CLRACC: ctrl.acc_mode = ACC_ZERO;
         OP_MOVACC: begin
            ctrl.reg_we = 1'b1;
            ctrl.wb_src = WB_ACC;
         end
         OP_LI: begin
            ctrl.reg_we = 1'b1;
            ctrl.wb_src = WB_IMM;
         end
         OP_LD: begin
            ctrl.reg_we = 1'b1;
            ctrl.wb_src = WB_MEM;
         end
         OP_ST:     ctrl.mem_we  = 1'b1;
         OP_SETW:   ctrl.wptr_ld = 1'b1;
         OP_SETS:   ctrl.sptr_ld = 1'b1;
         OP_BLEZ:   ctrl.branch  = 1'b1;
         OP_HALT:   ctrl.halt    = 1'b1;
         default:   ctrl = '0;
      endcase
   end

endmodule

// File: rtl/accmac_regfile.sv
module accmac_regfile #(
   parameter int NREG = 8,
   parameter int XLEN = 64,
   parameter int NRD  = 3,
   localparam int RB  = $clog2(NREG)
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [RB-1:0]            waddr,
   input  logic [XLEN-1:0]          wdata,
   input  logic [NRD-1:0][RB-1:0]   raddr,
   output logic [NRD-1:0][XLEN-1:0] rdata
);

   generate
      if (NREG != (1 << RB)) begin : g_bad_nreg
         $error("accmac_regfile: NREG must be a power of two");
      end
   endgenerate

   logic [XLEN-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (we) regs[waddr] <= wdata;
   end

   generate
      for (genvar p = 0; p < NRD; p++) begin : g_rd
         assign rdata[p] = regs[raddr[p]];
      end
   endgenerate

endmodule

// File: rtl/accmac_dmem.sv
module accmac_dmem #(
   parameter int IDX_W = 8,
   parameter int XLEN  = 64,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [XLEN-1:0]  wdata,
   output logic [XLEN-1:0]  rdata
);

   generate
      if (IDX_W > 10) begin : g_bad_depth
         $error("accmac_dmem: depth too large for a register array");
      end
   endgenerate

   logic [XLEN-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/accmac_mulacc.sv
module accmac_mulacc #(
   parameter int ELEM_W = 32,
   parameter int ACC_W  = 64,
   localparam int PROD_W = 2*ELEM_W
) (
   input  logic [ACC_W-1:0]  acc_in,
   input  logic [ELEM_W-1:0] op_a,
   input  logic [ELEM_W-1:0] op_b,
   output logic [ACC_W-1:0]  acc_next
);

   logic signed [PROD_W-1:0] prod;
   logic [ACC_W-1:0]         prod_ext;

   assign prod = $signed(op_a) * $signed(op_b);

   generate
      if (ACC_W > PROD_W) begin : g_widen
         assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
      end else if (ACC_W == PROD_W) begin : g_exact
         assign prod_ext = prod;
      end else begin : g_narrow
         assign prod_ext = prod[ACC_W-1:0];
      end
   endgenerate

   assign acc_next = acc_in + prod_ext;

endmodule

// File: rtl/accmac_core.sv
module accmac_core
   import accmac_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int ACC_W  = 64,
   parameter int ELEM_W = 32,
   parameter int NREG   = 8,
   parameter int LPTR_W = 16,
   parameter int KIDX_W = 8,
   parameter int DIDX_W = 8,
   parameter int IW     = 32,
   parameter int CNT_W  = 64,
   localparam int RB    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   output logic [XLEN-1:0]   imem_addr,
   input  logic [IW-1:0]     imem_data,
   output logic [KIDX_W-1:0] wt_idx,
   input  logic [ELEM_W-1:0] wt_data,
   output logic [KIDX_W-1:0] st_idx,
   input  logic [ELEM_W-1:0] st_data,
   input  logic [RB-1:0]     dbg_sel,
   output logic [XLEN-1:0]   dbg_data,
   output logic [ACC_W-1:0]  acc_out,
   output logic [CNT_W-1:0]  cycle_cnt,
   output logic [CNT_W-1:0]  retire_cnt,
   output logic              halted
);

   localparam int NRD = 3;

   generate
      if (ELEM_W > XLEN) begin : g_bad_elem
         $error("accmac_core: element wider than scalar word");
      end
      if (KIDX_W > LPTR_W) begin : g_bad_kidx
         $error("accmac_core: kernel index wider than pointer");
      end
      if (DIDX_W > XLEN) begin : g_bad_didx
         $error("accmac_core: data index wider than scalar word");
      end
      if (LPTR_W > XLEN) begin : g_bad_lptr
         $error("accmac_core: pointer wider than immediate word");
      end
   endgenerate

   logic [XLEN-1:0]  pc_q;
   logic [ACC_W-1:0] acc_q;
   logic [LPTR_W-1:0] wptr_q, sptr_q;
   logic             halted_q;
   logic [CNT_W-1:0] cyc_q, ret_q;

   logic [RB-1:0]   fld_a, fld_b;
   logic [XLEN-1:0] imm;
   ctrl_t           ctrl;

   accmac_decode #(.IW(IW), .RB(RB), .XLEN(XLEN)) u_dec (
      .instr (imem_data),
      .fld_a (fld_a),
      .fld_b (fld_b),
      .imm   (imm),
      .ctrl  (ctrl)
   );

   logic exec;
   assign exec = !halted_q;

   logic [NRD-1:0][RB-1:0]   rf_raddr;
   logic [NRD-1:0][XLEN-1:0] rf_rdata;
   logic [XLEN-1:0]          reg_a, reg_b, wb_data, acc_as_word, mem_rdata;

   assign rf_raddr[0] = fld_a;
   assign rf_raddr[1] = fld_b;
   assign rf_raddr[2] = dbg_sel;
   assign reg_a       = rf_rdata[0];
   assign reg_b       = rf_rdata[1];
   assign dbg_data    = rf_rdata[2];

   accmac_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD)) u_rf (
      .clk   (clk),
      .we    (exec && ctrl.reg_we),
      .waddr (fld_a),
      .wdata (wb_data),
      .raddr (rf_raddr),
      .rdata (rf_rdata)
   );

   logic [DIDX_W-1:0] mem_idx;
   assign mem_idx = ctrl.mem_we ? reg_a[DIDX_W-1:0] : reg_b[DIDX_W-1:0];

   accmac_dmem #(.IDX_W(DIDX_W), .XLEN(XLEN)) u_dm (
      .clk   (clk),
      .we    (exec && ctrl.mem_we),
      .idx   (mem_idx),
      .wdata (reg_b),
      .rdata (mem_rdata)
   );

   logic [ELEM_W-1:0] mac_a, mac_b;
   logic [ACC_W-1:0]  mac_sum;

   assign mac_a = ctrl.kernel ? wt_data : reg_a[ELEM_W-1:0];
   assign mac_b = ctrl.kernel ? st_data : reg_b[ELEM_W-1:0];

   accmac_mulacc #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_mac (
      .acc_in   (acc_q),
      .op_a     (mac_a),
      .op_b     (mac_b),
      .acc_next (mac_sum)
   );

   generate
      if (XLEN > ACC_W) begin : g_acc_sext
         assign acc_as_word = {{(XLEN-ACC_W){acc_q[ACC_W-1]}}, acc_q};
      end else if (XLEN == ACC_W) begin : g_acc_same
         assign acc_as_word = acc_q;
      end else begin : g_acc_trunc
         assign acc_as_word = acc_q[XLEN-1:0];
      end
   endgenerate

   always_comb begin
      unique case (ctrl.wb_src)
         WB_ACC:  wb_data = acc_as_word;
         WB_MEM:  wb_data = mem_rdata;
         default: wb_data = imm;
      endcase
   end

   logic br_taken;
   logic [XLEN-1:0] pc_next;

   assign br_taken = ctrl.branch && ($signed(reg_a) <= 0);

   always_comb begin
      if (ctrl.halt)     pc_next = pc_q;
      else if (br_taken) pc_next = pc_q + imm;
      else               pc_next = pc_q + XLEN'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= '0;
         acc_q    <= '0;
         wptr_q   <= '0;
         sptr_q   <= '0;
         halted_q <= 1'b0;
         cyc_q    <= '0;
         ret_q    <= '0;
      end else if (exec) begin
         pc_q  <= pc_next;
         cyc_q <= cyc_q + CNT_W'(1);
         ret_q <= ret_q + CNT_W'(1);
         if (ctrl.halt) halted_q <= 1'b1;
         unique case (ctrl.acc_mode)
            ACC_ZERO: acc_q <= '0;
            ACC_MAC:  acc_q <= mac_sum;
            default:  acc_q <= acc_q;
         endcase
         if (ctrl.wptr_ld)      wptr_q <= imm[LPTR_W-1:0];
         else if (ctrl.ptr_inc) wptr_q <= wptr_q + LPTR_W'(1);
         if (ctrl.sptr_ld)      sptr_q <= imm[LPTR_W-1:0];
         else if (ctrl.ptr_inc) sptr_q <= sptr_q + LPTR_W'(1);
      end
   end

   assign imem_addr  = pc_q;
   assign wt_idx     = wptr_q[KIDX_W-1:0];
   assign st_idx     = sptr_q[KIDX_W-1:0];
   assign acc_out    = acc_q;
   assign cycle_cnt  = cyc_q;
   assign retire_cnt = ret_q;
   assign halted     = halted_q;

   // R10: once halted, the flag stays set until reset
   a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
      halted_q |=> halted_q);

   // R10: a halted core freezes PC, accumulator and counters
   a_r10_freeze: assert property (@(posedge clk) disable iff (rst)
      halted_q |=> ($stable(pc_q) && $stable(acc_q) && $stable(cyc_q) && $stable(ret_q)));

   // R11: each executed cycle advances the cycle counter by one
   a_r11_count_step: assert property (@(posedge clk) disable iff (rst)
      !halted_q |=> (cyc_q == $past(cyc_q) + CNT_W'(1)));

   // R11: the two counters advance together
   a_r11_counters_match: assert property (@(posedge clk) disable iff (rst)
      cyc_q == ret_q);

   // R4: kernel MAC post-increments the weight pointer
   a_r4_ptr_inc: assert property (@(posedge clk) disable iff (rst)
      (!halted_q && ctrl.ptr_inc) |=> (wptr_q == $past(wptr_q) + LPTR_W'(1)));

   // R9: a non-branch, non-halt instruction falls through to PC+1
   a_r9_fallthrough: assert property (@(posedge clk) disable iff (rst)
      (!halted_q && !ctrl.branch && !ctrl.halt) |=> (pc_q == $past(pc_q) + XLEN'(1)));

endmodule

// File: tb/sim_accmac_core.sv
module sim_accmac_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] imem_addr;
   logic [31:0] imem_data;
   logic [7:0]  wt_idx, st_idx;
   logic [31:0] wt_data, st_data;
   logic [2:0]  dbg_sel = '0;
   logic [63:0] dbg_data, acc_out, cycle_cnt, retire_cnt;
   logic        halted;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   localparam logic [3:0] MAC = 4'd0, KMAC = 4'd1, CLR = 4'd2, MOV = 4'd3,
      LI = 4'd4, LD = 4'd5, ST = 4'd6, SETW = 4'd7, SETS = 4'd8,
      BLEZ = 4'd9, HALT = 4'd10;

   logic [31:0] prog [64];

   function automatic logic [31:0] enc(logic [3:0] op, int a, int b, int imm);
      logic [31:0] w;
      w = {op, a[2:0], b[2:0], imm[21:0]};
      return w;
   endfunction

   function automatic int wfn(int i);
      return i * 3 - 100;
   endfunction

   function automatic int sfn(int i);
      return 1000 - i * 7;
   endfunction

   assign imem_data = (imem_addr < 64) ? prog[imem_addr[5:0]] : {HALT, 28'd0};
   assign wt_data   = wfn(int'(wt_idx));
   assign st_data   = sfn(int'(st_idx));

   accmac_core u0 (
      .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
      .wt_idx(wt_idx), .wt_data(wt_data), .st_idx(st_idx), .st_data(st_data),
      .dbg_sel(dbg_sel), .dbg_data(dbg_data), .acc_out(acc_out),
      .cycle_cnt(cycle_cnt), .retire_cnt(retire_cnt), .halted(halted)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 64; i++) prog[i] = {HALT, 28'd0};
   endtask

   task automatic run_prog(string req);
      int n;
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      n = 0;
      while (!halted && n < 300) begin
         @(negedge clk);
         n++;
      end
      if (!halted) chk({req, " halt reached"}, 64'(halted), 64'd1);
   endtask

   task automatic rd(int r, output logic [63:0] v);
      dbg_sel = 3'(r);
      #1;
      v = dbg_data;
   endtask

   localparam int NV = 6;
   localparam int VA [NV] = '{3, -7, -1000, 0, 2097151, -2097152};
   localparam int VB [NV] = '{5, 9, -2000, 12345, 2097151, 2097151};

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] v, v2;
      longint e, r2e;
      int lo;

      // R3 R5 R6 R11: table of operand pairs, accumulated twice
      for (int k = 0; k < NV; k++) begin
         clear_prog();
         prog[0] = enc(LI, 1, 0, VA[k]);
         prog[1] = enc(LI, 2, 0, VB[k]);
         prog[2] = enc(CLR, 0, 0, 0);
         prog[3] = enc(MAC, 1, 2, 0);
         prog[4] = enc(MAC, 1, 2, 0);
         prog[5] = enc(MOV, 3, 0, 0);
         prog[6] = enc(HALT, 0, 0, 0);
         run_prog("R3");
         e = 2 * longint'(VA[k]) * longint'(VB[k]);
         chk("R3 acc", acc_out, e);
         rd(3, v);
         chk("R5 movacc", v, e);
         rd(1, v);
         chk("R6 li sext", v, longint'(VA[k]));
         chk("R11 cycles", cycle_cnt, 64'd7);
      end

      // R3: operand register with bits above 31
      clear_prog();
      prog[0] = enc(LI, 1, 0, 2097151);
      prog[1] = enc(CLR, 0, 0, 0);
      prog[2] = enc(MAC, 1, 1, 0);
      prog[3] = enc(MOV, 2, 0, 0);
      prog[4] = enc(CLR, 0, 0, 0);
      prog[5] = enc(MAC, 2, 2, 0);
      prog[6] = enc(HALT, 0, 0, 0);
      run_prog("R3");
      r2e = 64'd2097151 * 64'd2097151;
      rd(2, v);
      chk("R3 wide reg", v, r2e);
      lo = int'(r2e[31:0]);
      e = longint'(lo) * longint'(lo);
      chk("R3 low32 signed", acc_out, e);

      // R3: wrap modulo 2^64
      clear_prog();
      prog[0] = enc(LI, 1, 0, 32768);
      prog[1] = enc(LI, 2, 0, 65536);
      prog[2] = enc(CLR, 0, 0, 0);
      prog[3] = enc(MAC, 1, 2, 0);
      prog[4] = enc(MOV, 3, 0, 0);
      prog[5] = enc(CLR, 0, 0, 0);
      prog[6] = enc(MAC, 3, 3, 0);
      prog[7] = enc(MAC, 3, 3, 0);
      prog[8] = enc(MAC, 3, 3, 0);
      prog[9] = enc(HALT, 0, 0, 0);
      run_prog("R3");
      rd(3, v);
      chk("R3 2^31 reg", v, 64'h0000_0000_8000_0000);
      chk("R3 wrap", acc_out, 64'hC000_0000_0000_0000);

      // R4 R8: kernel MAC at mid pointers, sptr immediate truncated
      clear_prog();
      prog[0] = enc(SETW, 0, 0, 5);
      prog[1] = enc(SETS, 0, 0, 32'h10003);
      prog[2] = enc(CLR, 0, 0, 0);
      prog[3] = enc(KMAC, 0, 0, 0);
      prog[4] = enc(KMAC, 0, 0, 0);
      prog[5] = enc(KMAC, 0, 0, 0);
      prog[6] = enc(HALT, 0, 0, 0);
      run_prog("R4");
      e = 0;
      for (int i = 0; i < 3; i++) e += longint'(wfn(5 + i)) * longint'(sfn(3 + i));
      chk("R4 kernel acc", acc_out, e);
      chk("R8 wptr kept", 64'(wt_idx), 64'd8);
      chk("R4 sptr inc", 64'(st_idx), 64'd6);

      // R1: reset clears state reached above
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1 pc", imem_addr, 64'd0);
      chk("R1 acc", acc_out, 64'd0);
      chk("R1 wptr", 64'(wt_idx), 64'd0);
      chk("R1 sptr", 64'(st_idx), 64'd0);
      chk("R1 halted", 64'(halted), 64'd0);
      chk("R1 cycles", cycle_cnt, 64'd0);
      chk("R1 retired", retire_cnt, 64'd0);

      // R4: pointer and index wrap
      clear_prog();
      prog[0] = enc(SETW, 0, 0, 32'hFFFF);
      prog[1] = enc(SETS, 0, 0, 32'h1FF);
      prog[2] = enc(CLR, 0, 0, 0);
      prog[3] = enc(KMAC, 0, 0, 0);
      prog[4] = enc(HALT, 0, 0, 0);
      run_prog("R4");
      chk("R4 wrap acc", acc_out, longint'(wfn(255)) * longint'(sfn(255)));
      chk("R4 wptr wrap", 64'(wt_idx), 64'd0);
      chk("R4 sptr index wrap", 64'(st_idx), 64'd0);

      // R7: store/load through low 8 bits of the address
      clear_prog();
      prog[0] = enc(LI, 1, 0, 32'h305);
      prog[1] = enc(LI, 2, 0, -12345);
      prog[2] = enc(ST, 1, 2, 0);
      prog[3] = enc(LI, 3, 0, 5);
      prog[4] = enc(LD, 4, 3, 0);
      prog[5] = enc(HALT, 0, 0, 0);
      run_prog("R7");
      rd(4, v);
      chk("R7 ld/st", v, -64'sd12345);

      // R9 R10: taken forward, not taken, taken backward, then halt freeze
      clear_prog();
      prog[0] = enc(LI, 6, 0, 0);
      prog[1] = enc(LI, 1, 0, 0);
      prog[2] = enc(BLEZ, 1, 0, 4);
      prog[3] = enc(LI, 6, 0, 11);
      prog[4] = enc(LI, 7, 0, 33);
      prog[5] = enc(HALT, 0, 0, 0);
      prog[6] = enc(LI, 2, 0, 5);
      prog[7] = enc(BLEZ, 2, 0, 9);
      prog[8] = enc(LI, 3, 0, -1);
      prog[9] = enc(BLEZ, 3, 0, -5);
      run_prog("R9");
      rd(6, v);
      chk("R9 skipped", v, 64'd0);
      rd(7, v);
      chk("R9 backward target", v, 64'd33);
      chk("R9 path length", cycle_cnt, 64'd9);
      chk("R10 pc held", imem_addr, 64'd5);
      repeat (10) @(negedge clk);
      chk("R10 cycles frozen", cycle_cnt, 64'd9);
      chk("R10 retired frozen", retire_cnt, 64'd9);
      chk("R10 still halted", 64'(halted), 64'd1);

      // R12: undefined opcode is a no-op
      clear_prog();
      prog[0] = enc(LI, 1, 0, 7);
      prog[1] = 32'hF000_0000;
      prog[2] = enc(LI, 2, 0, 8);
      prog[3] = enc(HALT, 0, 0, 0);
      run_prog("R12");
      rd(1, v);
      rd(2, v2);
      chk("R12 r1", v, 64'd7);
      chk("R12 r2 after", v2, 64'd8);
      chk("R12 cycles", cycle_cnt, 64'd4);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule